// File: doc/BRIEF.md
# Partially Decoded Serial Port Register Block

This block is the register face of a simple asynchronous serial port as seen from an 8-bit CPU I/O bus. The CPU reaches it with ordinary I/O read and write cycles. Every port from 0x80 to 0xBF hits the block because the select uses only two address lines and the opcode-fetch strobe. Address bit 0 picks between the control/status pair and the data pair. Bit framing and the baud clock are handled elsewhere. On the far side the block trades whole bytes with a host agent through a valid/ready transmit path and a valid/busy receive path, and it drives a request-to-send line that the CPU controls.

The interrupt output is active low and meant to be wired straight to the CPU's maskable interrupt input. The block never claims an interrupt acknowledge cycle, so its read port stays released and the CPU sees an all-ones byte. A write of binary 11 into the two low control bits parks the block in a master-reset state. It leaves that state only when a different value is written there. The block also comes out of system reset in this state.

Top module: `acia_regs_top`

## Requirements
- R1: The block is selected only when iorq_n is low, m1_n is high, addr[7] is 1 and addr[6] is 0, so all of ports 0x80..0xBF alias it. With addr[0]=0 the CPU writes control and reads status, and with addr[0]=1 it writes transmit data and reads receive data. A cycle outside this window changes nothing and leaves dout_en low with dout at 0xFF.
- R2: A cycle with iorq_n and m1_n both low (interrupt acknowledge) never selects the block, whatever the address and strobes: dout_en stays low, dout reads 0xFF and no register changes.
- R3: The status byte has receive-full in bit 0, transmit-empty in bit 1, the interrupt request (the inverse of irq_n) in bit 7, and zeros in bits 6:2.
- R4: While control bits 1:0 equal 11, which is also the value after rst_n: receive-full and transmit-full are clear, irq_n is high, rx_busy is high, and CPU data writes and host bytes are ignored. Writing any other value to bits 1:0 resumes normal operation with both data flags still clear.
- R5: Control bit 6 set to 1 drives rts_n high and forces rx_busy high, and no host byte is taken while it is set. Control bit 6 set to 0 drives rts_n low.
- R6: A host byte is taken in the cycle where rx_valid is high and rx_busy is low. It sets receive-full, which keeps rx_busy high. A CPU read of the data port returns that byte, and receive-full clears once the read cycle ends, however many clocks the cycle is held.
- R7: A CPU data write loads tx_data, raises tx_valid and clears transmit-empty. The byte is held until a clock with tx_valid and tx_ready both high, after which tx_valid drops.
- R8: irq_n is low exactly when the block is not in master reset and either control bit 7 is 1 with receive-full set, or control bit 5 is 1 with transmit-empty set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| iorq_n | input | 1 | CPU I/O request, active low |
| m1_n | input | 1 | CPU opcode fetch / acknowledge marker, active low |
| rd_n | input | 1 | CPU read strobe, active low |
| wr_n | input | 1 | CPU write strobe, active low |
| addr | input | 8 | CPU I/O port address |
| din | input | 8 | CPU write data |
| dout | output | 8 | CPU read data, 0xFF when not driven |
| dout_en | output | 1 | Block is driving the read data |
| irq_n | output | 1 | Interrupt request to the CPU, active low |
| rts_n | output | 1 | Request to send, active low |
| rx_valid | input | 1 | Host offers a received byte |
| rx_data | input | 8 | Received byte from the host |
| rx_busy | output | 1 | Host must not offer a byte |
| tx_valid | output | 1 | Transmit byte waiting for the host |
| tx_data | output | 8 | Transmit byte |
| tx_ready | input | 1 | Host takes the transmit byte |

## Verification
The hardest state to reach is the master-reset corner with both data registers loaded and both interrupt enables set. From there the bench must show that the flags drop, the interrupt stays quiet, and later data writes and host bytes leave no trace. The stimulus first fills the receive register from the host and leaves a transmit byte unconsumed by holding tx_ready low. It then writes a control value that sets both enables together with the reset code, and it probes status, tx_valid, rx_busy and a second round of writes before it writes a normal control value. The other hard cases are a read held for several clocks and accesses at aliased ports and during interrupt acknowledge. Each is driven through the bus tasks, and every status read is scored against a queued expectation.

// File: rtl/acia_pkg.sv
package acia_pkg;

    localparam int DATA_W = 8;

    // control fields the block acts on; bits 4:2 carry no function
    typedef struct packed {
        logic       rx_ie;    // bit 7
        logic       rts_off;  // bit 6
        logic       tx_ie;    // bit 5
        logic [1:0] mode;     // bits 1:0
    } ctrl_t;

    localparam logic [1:0] MODE_MRESET = 2'b11;

    localparam int ST_RXF = 0;
    localparam int ST_TXE = 1;
    localparam int ST_IRQ = 7;

    localparam logic [DATA_W-1:0] BUS_IDLE = '1;

    function automatic ctrl_t ctrl_from_byte(input logic [DATA_W-1:0] b);
        ctrl_t c;
        c.rx_ie   = b[7];
        c.rts_off = b[6];
        c.tx_ie   = b[5];
        c.mode    = b[1:0];
        return c;
    endfunction

endpackage

// File: rtl/acia_bus_decode.sv
module acia_bus_decode #(
    parameter int          AW        = 8,
    parameter logic [7:0]  SEL_MASK  = 8'hC0,
    parameter logic [7:0]  SEL_MATCH = 8'h80,
    parameter int          RS_BIT    = 0
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          iorq_n,
    input  logic          m1_n,
    input  logic          rd_n,
    input  logic          wr_n,
    input  logic [AW-1:0] addr,
    output logic          rd_sel,
    output logic          reg_sel,
    output logic          wr_ctrl_stb,
    output logic          wr_data_stb,
    output logic          rd_data_done
);

    typedef struct packed {
        logic wr_act;
        logic rd_data_act;
    } dec_state_t;

    dec_state_t st_q, st_d;

    logic sel;
    logic wr_now;
    logic rd_data_now;
    logic wr_stb;

    always_comb begin
        sel         = !iorq_n && m1_n &&
                      ((addr & AW'(SEL_MASK)) == AW'(SEL_MATCH));
        reg_sel     = addr[RS_BIT];
        rd_sel      = sel && !rd_n;
        wr_now      = sel && !wr_n;
        rd_data_now = rd_sel && reg_sel;
        wr_stb      = wr_now && !st_q.wr_act;
        wr_ctrl_stb = wr_stb && !reg_sel;
        wr_data_stb = wr_stb && reg_sel;
        // a data read takes effect when its cycle ends
        rd_data_done = st_q.rd_data_act && !rd_data_now;

        st_d             = st_q;
        st_d.wr_act      = wr_now;
        st_d.rd_data_act = rd_data_now;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

endmodule

// File: rtl/acia_ctrl_reg.sv
module acia_ctrl_reg
    import acia_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_stb,
    input  logic [DATA_W-1:0] din,
    output ctrl_t             ctrl,
    output logic              mreset
);

    ctrl_t ctrl_q, ctrl_d;

    always_comb begin
        ctrl_d = ctrl_q;
        if (wr_stb) begin
            ctrl_d = ctrl_from_byte(din);
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            ctrl_q         <= '0;
            ctrl_q.mode    <= MODE_MRESET;
        end else begin
            ctrl_q <= ctrl_d;
        end
    end

    assign ctrl   = ctrl_q;
    assign mreset = (ctrl_q.mode == MODE_MRESET);

endmodule

// File: rtl/acia_data_path.sv
module acia_data_path
    import acia_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              mreset,
    input  logic              rts_off,
    input  logic              wr_data_stb,
    input  logic [DATA_W-1:0] din,
    input  logic              rd_data_done,
    input  logic              rx_valid,
    input  logic [DATA_W-1:0] rx_data,
    input  logic              tx_ready,
    output logic              rx_full,
    output logic              tx_full,
    output logic [DATA_W-1:0] rx_hold,
    output logic [DATA_W-1:0] tx_hold,
    output logic              rx_busy
);

    typedef struct packed {
        logic              rx_full;
        logic              tx_full;
        logic [DATA_W-1:0] rx_hold;
        logic [DATA_W-1:0] tx_hold;
    } dp_state_t;

    dp_state_t st_q, st_d;
    logic      busy;

    always_comb begin
        busy = mreset || rts_off || st_q.rx_full;
        st_d = st_q;
        if (mreset) begin
            st_d.rx_full = 1'b0;
            st_d.tx_full = 1'b0;
        end else begin
            if (st_q.tx_full && tx_ready) begin
                st_d.tx_full = 1'b0;
            end
            if (wr_data_stb) begin
                st_d.tx_full = 1'b1;
                st_d.tx_hold = din;
            end
            if (rd_data_done) begin
                st_d.rx_full = 1'b0;
            end
            if (rx_valid && !busy) begin
                st_d.rx_full = 1'b1;
                st_d.rx_hold = rx_data;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign rx_full = st_q.rx_full;
    assign tx_full = st_q.tx_full;
    assign rx_hold = st_q.rx_hold;
    assign tx_hold = st_q.tx_hold;
    assign rx_busy = busy;

endmodule

// File: rtl/acia_irq_gen.sv
module acia_irq_gen
    import acia_pkg::*;
(
    input  ctrl_t ctrl,
    input  logic  mreset,
    input  logic  rx_full,
    input  logic  tx_full,
    output logic  irq_req
);

    logic rx_cause;
    logic tx_cause;

    always_comb begin
        rx_cause = ctrl.rx_ie && rx_full;
        tx_cause = ctrl.tx_ie && !tx_full;
        irq_req  = !mreset && (rx_cause || tx_cause);
    end

endmodule

// File: rtl/acia_regs_top.sv
module acia_regs_top
    import acia_pkg::*;
#(
    parameter int         AW        = 8,
    parameter logic [7:0] SEL_MASK  = 8'hC0,
    parameter logic [7:0] SEL_MATCH = 8'h80
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              iorq_n,
    input  logic              m1_n,
    input  logic              rd_n,
    input  logic              wr_n,
    input  logic [AW-1:0]     addr,
    input  logic [DATA_W-1:0] din,
    output logic [DATA_W-1:0] dout,
    output logic              dout_en,
    output logic              irq_n,
    output logic              rts_n,
    input  logic              rx_valid,
    input  logic [DATA_W-1:0] rx_data,
    output logic              rx_busy,
    output logic              tx_valid,
    output logic [DATA_W-1:0] tx_data,
    input  logic              tx_ready
);

    logic              rd_sel;
    logic              reg_sel;
    logic              wr_ctrl_stb;
    logic              wr_data_stb;
    logic              rd_data_done;
    ctrl_t             ctrl;
    logic              mreset;
    logic              rx_full;
    logic              tx_full;
    logic [DATA_W-1:0] rx_hold;
    logic [DATA_W-1:0] tx_hold;
    logic              irq_req;
    logic [DATA_W-1:0] status;

    acia_bus_decode #(
        .AW        (AW),
        .SEL_MASK  (SEL_MASK),
        .SEL_MATCH (SEL_MATCH),
        .RS_BIT    (0)
    ) i_dec (
        .clk          (clk),
        .rst_n        (rst_n),
        .iorq_n       (iorq_n),
        .m1_n         (m1_n),
        .rd_n         (rd_n),
        .wr_n         (wr_n),
        .addr         (addr),
        .rd_sel       (rd_sel),
        .reg_sel      (reg_sel),
        .wr_ctrl_stb  (wr_ctrl_stb),
        .wr_data_stb  (wr_data_stb),
        .rd_data_done (rd_data_done)
    );

    acia_ctrl_reg i_ctrl (
        .clk    (clk),
        .rst_n  (rst_n),
        .wr_stb (wr_ctrl_stb),
        .din    (din),
        .ctrl   (ctrl),
        .mreset (mreset)
    );

    acia_data_path i_dp (
        .clk          (clk),
        .rst_n        (rst_n),
        .mreset       (mreset),
        .rts_off      (ctrl.rts_off),
        .wr_data_stb  (wr_data_stb),
        .din          (din),
        .rd_data_done (rd_data_done),
        .rx_valid     (rx_valid),
        .rx_data      (rx_data),
        .tx_ready     (tx_ready),
        .rx_full      (rx_full),
        .tx_full      (tx_full),
        .rx_hold      (rx_hold),
        .tx_hold      (tx_hold),
        .rx_busy      (rx_busy)
    );

    acia_irq_gen i_irq (
        .ctrl    (ctrl),
        .mreset  (mreset),
        .rx_full (rx_full),
        .tx_full (tx_full),
        .irq_req (irq_req)
    );

    always_comb begin
        status         = '0;
        status[ST_RXF] = rx_full;
        status[ST_TXE] = !tx_full;
        status[ST_IRQ] = irq_req;

        dout    = BUS_IDLE;
        dout_en = rd_sel;
        if (rd_sel) begin
            dout = reg_sel ? rx_hold : status;
        end
    end

    assign irq_n    = !irq_req;
    assign rts_n    = ctrl.rts_off;
    assign tx_valid = tx_full;
    assign tx_data  = tx_hold;

endmodule

// File: rtl/acia_regs_chk.sv
module acia_regs_chk (
    input logic       clk,
    input logic       rst_n,
    input logic       iorq_n,
    input logic       m1_n,
    input logic       rd_n,
    input logic [7:0] addr,
    input logic [7:0] dout,
    input logic       dout_en,
    input logic       irq_n,
    input logic       rts_n,
    input logic       rx_valid,
    input logic       rx_busy,
    input logic       tx_valid,
    input logic [7:0] tx_data,
    input logic       tx_ready
);

    AST_ACK_SILENT: assert property (@(posedge clk) disable iff (!rst_n)
        (!iorq_n && !m1_n) |-> (!dout_en && dout == 8'hFF)); // R2

    AST_DRIVE_IN_WINDOW: assert property (@(posedge clk) disable iff (!rst_n)
        dout_en |-> (!iorq_n && m1_n && !rd_n && addr[7] && !addr[6])); // R1

    AST_STATUS_IRQ_BIT: assert property (@(posedge clk) disable iff (!rst_n)
        (dout_en && !addr[0]) |-> (dout[7] == !irq_n)); // R3

    AST_RTS_FORCES_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
        rts_n |-> rx_busy); // R5

    AST_RX_TAKE_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
        (rx_valid && !rx_busy) |=> rx_busy); // R6

    AST_TX_HELD: assert property (@(posedge clk) disable iff (!rst_n)
        (tx_valid && !tx_ready && iorq_n) |=> (tx_valid && $stable(tx_data))); // R7

endmodule

bind acia_regs_top acia_regs_chk i_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .iorq_n   (iorq_n),
    .m1_n     (m1_n),
    .rd_n     (rd_n),
    .addr     (addr),
    .dout     (dout),
    .dout_en  (dout_en),
    .irq_n    (irq_n),
    .rts_n    (rts_n),
    .rx_valid (rx_valid),
    .rx_busy  (rx_busy),
    .tx_valid (tx_valid),
    .tx_data  (tx_data),
    .tx_ready (tx_ready)
);

// File: tb/test_acia_regs_top.sv
module test_acia_regs_top;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       iorq_n = 1'b1;
    logic       m1_n = 1'b1;
    logic       rd_n = 1'b1;
    logic       wr_n = 1'b1;
    logic [7:0] addr = 8'h00;
    logic [7:0] din = 8'h00;
    logic [7:0] dout;
    logic       dout_en;
    logic       irq_n;
    logic       rts_n;
    logic       rx_valid = 1'b0;
    logic [7:0] rx_data = 8'h00;
    logic       rx_busy;
    logic       tx_valid;
    logic [7:0] tx_data;
    logic       tx_ready = 1'b0;

    int n_checks = 0;
    int n_errors = 0;
    bit finished = 1'b0;

    typedef struct {
        logic [7:0] val;
        string      req;
    } exp_t;

    exp_t sbq[$];
    event rd_ev;

    always #5 clk = ~clk;

    acia_regs_top i_acia_regs_top (
        .clk      (clk),
        .rst_n    (rst_n),
        .iorq_n   (iorq_n),
        .m1_n     (m1_n),
        .rd_n     (rd_n),
        .wr_n     (wr_n),
        .addr     (addr),
        .din      (din),
        .dout     (dout),
        .dout_en  (dout_en),
        .irq_n    (irq_n),
        .rts_n    (rts_n),
        .rx_valid (rx_valid),
        .rx_data  (rx_data),
        .rx_busy  (rx_busy),
        .tx_valid (tx_valid),
        .tx_data  (tx_data),
        .tx_ready (tx_ready)
    );

    task automatic chk(input string req, input logic [7:0] act, input logic [7:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_errors++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic finish_run();
        if (!finished) begin
            finished = 1'b1;
            $display("CHECKS %0d ERRORS %0d", n_checks, n_errors);
            $finish;
        end
    endtask

    // scoreboard monitor: compares every scored read against the queue
    initial begin
        forever begin
            @(rd_ev);
            if (sbq.size() == 0) begin
                n_checks++;
                n_errors++;
                $display("FAIL scoreboard actual=%h expected=empty queue", dout);
            end else begin
                exp_t e;
                e = sbq.pop_front();
                chk({e.req, " dout_en"}, {7'b0, dout_en}, 8'h01);
                chk(e.req, dout, e.val);
            end
        end
    end

    task automatic io_wr(input logic [7:0] a, input logic [7:0] d);
        @(negedge clk);
        addr = a; din = d; iorq_n = 1'b0; wr_n = 1'b0;
        repeat (2) @(negedge clk);
        iorq_n = 1'b1; wr_n = 1'b1;
        @(negedge clk);
    endtask

    task automatic io_rd(input logic [7:0] a, input logic [7:0] exp,
                         input string req, input int hold);
        exp_t e;
        @(negedge clk);
        addr = a; iorq_n = 1'b0; rd_n = 1'b0;
        e.val = exp; e.req = req;
        sbq.push_back(e);
        @(posedge clk);
        #2;
        -> rd_ev;
        repeat (hold) @(negedge clk);
        iorq_n = 1'b1; rd_n = 1'b1;
        @(negedge clk);
    endtask

    task automatic host_push(input logic [7:0] d);
        @(negedge clk);
        rx_valid = 1'b1; rx_data = d;
        @(negedge clk);
        rx_valid = 1'b0;
    endtask

    task automatic host_take();
        @(negedge clk);
        tx_ready = 1'b1;
        @(negedge clk);
        tx_ready = 1'b0;
    endtask

    initial begin
        #(100_000 * 10);
        n_checks++;
        n_errors++;
        $display("FAIL watchdog actual=running expected=done");
        finish_run();
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);

        // R4 power-up lands in master reset
        chk("R4 reset rx_busy", {7'b0, rx_busy}, 8'h01);
        chk("R4 reset irq_n", {7'b0, irq_n}, 8'h01);
        chk("R4 reset tx_valid", {7'b0, tx_valid}, 8'h00);
        chk("R5 reset rts_n", {7'b0, rts_n}, 8'h00);
        io_rd(8'h80, 8'h02, "R3 R4 reset status", 1);

        io_wr(8'h80, 8'h00);
        chk("R5 rx_busy after release", {7'b0, rx_busy}, 8'h00);

        // R6 receive path, read through aliases
        host_push(8'h5A);
        chk("R6 busy while full", {7'b0, rx_busy}, 8'h01);
        io_rd(8'hBE, 8'h03, "R1 R3 alias status", 1);
        io_rd(8'h81, 8'h5A, "R6 data read", 1);
        chk("R6 busy cleared", {7'b0, rx_busy}, 8'h00);

        // R1 out-of-window accesses
        io_wr(8'hC1, 8'h11);
        chk("R1 A6=1 write ignored", {7'b0, tx_valid}, 8'h00);
        io_wr(8'h41, 8'h12);
        chk("R1 A7=0 write ignored", {7'b0, tx_valid}, 8'h00);
        @(negedge clk);
        addr = 8'h01; iorq_n = 1'b0; rd_n = 1'b0;
        @(negedge clk);
        chk("R1 outside read dout_en", {7'b0, dout_en}, 8'h00);
        chk("R1 outside read dout", dout, 8'hFF);
        iorq_n = 1'b1; rd_n = 1'b1;

        // R2 acknowledge cycle never selects
        @(negedge clk);
        addr = 8'h81; din = 8'h77; iorq_n = 1'b0; m1_n = 1'b0; wr_n = 1'b0;
        @(negedge clk);
        chk("R2 ack dout_en", {7'b0, dout_en}, 8'h00);
        chk("R2 ack dout", dout, 8'hFF);
        iorq_n = 1'b1; m1_n = 1'b1; wr_n = 1'b1;
        @(negedge clk);
        chk("R2 ack write ignored", {7'b0, tx_valid}, 8'h00);

        // R7 transmit path
        io_wr(8'h81, 8'hA5);
        chk("R7 tx_valid", {7'b0, tx_valid}, 8'h01);
        chk("R7 tx_data", tx_data, 8'hA5);
        io_rd(8'h80, 8'h00, "R7 status tx full", 1);
        host_take();
        chk("R7 consumed", {7'b0, tx_valid}, 8'h00);
        io_rd(8'h9A, 8'h02, "R7 R1 status tx empty", 1);

        // R8 interrupt causes
        io_wr(8'h80, 8'h20);
        chk("R8 tx irq", {7'b0, irq_n}, 8'h00);
        io_rd(8'h80, 8'h82, "R8 R3 status irq bit", 1);
        io_wr(8'h80, 8'h80);
        chk("R8 rx irq idle", {7'b0, irq_n}, 8'h01);
        host_push(8'h3C);
        chk("R8 rx irq asserted", {7'b0, irq_n}, 8'h00);
        io_rd(8'h80, 8'h83, "R8 status rx irq", 1);
        io_rd(8'h81, 8'h3C, "R6 R8 data read", 1);
        chk("R8 rx irq cleared", {7'b0, irq_n}, 8'h01);

        // R5 RTS gates the host
        io_wr(8'h80, 8'h40);
        chk("R5 rts_n high", {7'b0, rts_n}, 8'h01);
        chk("R5 busy with rts off", {7'b0, rx_busy}, 8'h01);
        host_push(8'h99);
        io_wr(8'h80, 8'h00);
        chk("R5 rts_n low", {7'b0, rts_n}, 8'h00);
        io_rd(8'h80, 8'h02, "R5 byte refused", 1);

        // R4 master reset with both registers loaded and both enables set
        host_push(8'h44);
        io_wr(8'h81, 8'h55);
        io_rd(8'h80, 8'h01, "R4 loaded status", 1);
        io_wr(8'h80, 8'hA3);
        chk("R4 mreset tx_valid", {7'b0, tx_valid}, 8'h00);
        chk("R4 mreset irq_n", {7'b0, irq_n}, 8'h01);
        chk("R4 mreset rx_busy", {7'b0, rx_busy}, 8'h01);
        io_rd(8'h80, 8'h02, "R4 mreset status", 1);
        io_wr(8'h81, 8'h33);
        chk("R4 data write ignored", {7'b0, tx_valid}, 8'h00);
        host_push(8'h66);
        io_wr(8'h80, 8'h00);
        io_rd(8'h80, 8'h02, "R4 after release status", 1);
        chk("R4 after release rx_busy", {7'b0, rx_busy}, 8'h00);

        // R6 long read counts once
        host_push(8'h7E);
        io_rd(8'hA7, 8'h7E, "R6 held read", 4);
        io_rd(8'h80, 8'h02, "R6 cleared after held read", 1);

        repeat (2) @(negedge clk);
        if (sbq.size() != 0) begin
            n_checks++;
            n_errors++;
            $display("FAIL scoreboard actual=%0d expected=0 pending", sbq.size());
        end
        finish_run();
    end

endmodule